// File: doc/BRIEF.md
# Zigzag Scan Coordinate Generator

This block walks an 8x8 pixel block in the diagonal zigzag order used for transform coefficients and emits one coordinate per accepted beat. No order table is stored. A small controller runs a program of movement primitives. Each primitive is a step vector plus a rule that ends it: a single step, or a run that stops at a block edge. An x/y counter applies the current primitive's step. The upper-left triangle comes from a lead step and three rounds of four primitives. One run along the anti-diagonal follows. The lower-right triangle comes from the same primitives in reverse order, with the run-ending edges moved to the far side of the block.

A consumer pulses `start` while the block is idle. It then takes coordinates with `advance` whenever `valid` is high. Column (`x`) and row (`y`) are 1-based: x grows to the right and y grows downward. `addr` gives the row-major index of the same point. The final point raises `last`. Once that beat is accepted, the block goes idle again.

Top module: `zigzag_scan_gen`

## Requirements
- R1: After reset, `valid` and `last` are 0.
- R2: A `start` pulse while `valid` is 0 makes `valid` 1 on the next cycle, with x=1, y=1 and addr=0.
- R3: While `valid` is 1, `addr` equals (y-1)*8+(x-1).
- R4: From [1,1] the block takes one step east (+1,0). It then does three rounds of four primitives: a southwest run (-1,+1) that ends on column 1, one south step (0,+1), a northeast run (+1,-1) that ends on row 1, and one east step. The 29th coordinate is [8,1].
- R5: The next seven coordinates are a southwest run along the anti-diagonal, from [7,2] down to [1,8].
- R6: The lower triangle follows as three rounds of: one east step, a northeast run that ends on column 8, one south step, and a southwest run that ends on row 8. One final east step ends the scan at [8,8]. No run exceeds 8 steps.
- R7: Exactly 64 coordinates are emitted, each point of the block once. `last` is 1 only with the 64th coordinate, [8,8].
- R8: Once the beat with `last` is accepted, `valid` is 0 on the next cycle and stays 0 whatever `advance` does. A new `start` begins a fresh scan at [1,1].
- R9: While `valid` is 1 and `advance` is 0, `x`, `y`, `addr`, `valid` and `last` keep their values on the next cycle.
- R10: A `start` pulse while `valid` is 1 has no effect: the scan continues with the coordinate it would have produced anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan when the block is idle |
| advance | input | 1 | Consumer accepts the current coordinate |
| valid | output | 1 | A coordinate is presented |
| last | output | 1 | The presented coordinate is the final one |
| x | output | 4 | Column, 1 to 8 |
| y | output | 4 | Row, 1 to 8 |
| addr | output | 6 | Row-major index (y-1)*8+(x-1) |

## Verification
Every emitted point is compared with an order the bench builds by listing anti-diagonals, alternating the direction on each one. A run that stops one point early or late at an edge therefore shows up as a mismatch at that index. So does a second half that does not move the ending edges, which would leave the block and never reach [8,8]. One pass runs without stalls. A second pass uses pseudo-random stalls, to catch a controller that moves on while `advance` is low. That pass also raises `start` in the middle of the scan, which would send a careless design back to [1,1]. After the final beat the bench holds `advance` high to show that the block stays idle, and it then restarts the block to check that the internal counters were cleared.

// File: rtl/zz_scan_pkg.sv
package zz_scan_pkg;

  // Movement primitives applied by the x/y counter
  typedef enum logic [1:0] {
    MV_EAST  = 2'd0,
    MV_SOUTH = 2'd1,
    MV_SWEST = 2'd2,
    MV_NEAST = 2'd3
  } move_e;

  // Program position of the sequencer
  typedef enum logic [2:0] {
    PH_LEAD  = 3'd0,   // single east step opening the upper triangle
    PH_UPPER = 3'd1,   // rounds of the upper triangle
    PH_DIAG  = 3'd2,   // anti-diagonal run
    PH_LOWER = 3'd3,   // rounds of the lower triangle (reversed order)
    PH_TAIL  = 3'd4,   // closing east step
    PH_DONE  = 3'd5    // idle / scan complete
  } phase_e;

  function automatic move_e upper_move(input logic [1:0] slot);
    case (slot)
      2'd0:    return MV_SWEST;
      2'd1:    return MV_SOUTH;
      2'd2:    return MV_NEAST;
      default: return MV_EAST;
    endcase
  endfunction

  // Lower triangle replays the upper round backwards
  function automatic move_e lower_move(input logic [1:0] slot);
    case (slot)
      2'd0:    return MV_EAST;
      2'd1:    return MV_NEAST;
      2'd2:    return MV_SOUTH;
      default: return MV_SWEST;
    endcase
  endfunction

  function automatic logic signed [1:0] move_dx(input move_e m);
    case (m)
      MV_EAST:  return 2'sd1;
      MV_NEAST: return 2'sd1;
      MV_SWEST: return -2'sd1;
      default:  return 2'sd0;
    endcase
  endfunction

  function automatic logic signed [1:0] move_dy(input move_e m);
    case (m)
      MV_SOUTH: return 2'sd1;
      MV_SWEST: return 2'sd1;
      MV_NEAST: return -2'sd1;
      default:  return 2'sd0;
    endcase
  endfunction

  function automatic logic move_repeats(input move_e m);
    return (m == MV_SWEST) || (m == MV_NEAST);
  endfunction

  // Row-major index from 1-based column/row
  function automatic int lin_index(input int col, input int row, input int side);
    return (row - 1) * side + (col - 1);
  endfunction

endpackage

// File: rtl/zz_xy_counter.sv
module zz_xy_counter
  import zz_scan_pkg::*;
#(
  parameter int SIDE = 8,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          step,
  input  move_e         move,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic          at_west,
  output logic          at_north,
  output logic          at_east,
  output logic          at_south
);

  localparam logic [CW-1:0] EDGE_LO = CW'(1);
  localparam logic [CW-1:0] EDGE_HI = CW'(SIDE);

  logic signed [1:0] dx, dy;
  logic [CW-1:0]     nx, ny;

  always_comb begin
    dx = move_dx(move);
    dy = move_dy(move);
    nx = x + {{(CW-2){dx[1]}}, dx};
    ny = y + {{(CW-2){dy[1]}}, dy};
  end

  // Edge flags describe the coordinate the pending step lands on
  assign at_west  = (nx == EDGE_LO);
  assign at_north = (ny == EDGE_LO);
  assign at_east  = (nx == EDGE_HI);
  assign at_south = (ny == EDGE_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= EDGE_LO;
      y <= EDGE_LO;
    end else if (launch) begin
      x <= EDGE_LO;
      y <= EDGE_LO;
    end else if (step) begin
      x <= nx;
      y <= ny;
    end
  end

  assert_coord_in_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (x >= EDGE_LO) && (x <= EDGE_HI) && (y >= EDGE_LO) && (y <= EDGE_HI));

  assert_step_moves_point_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && !launch |=> (x != $past(x)) || (y != $past(y)));

endmodule

// File: rtl/zz_seq_ctrl.sv
module zz_seq_ctrl
  import zz_scan_pkg::*;
#(
  parameter int SIDE = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  logic  step,
  input  logic  at_west,
  input  logic  at_north,
  input  logic  at_east,
  input  logic  at_south,
  output move_e move,
  output logic  tail_step
);

  localparam int GROUPS = SIDE / 2 - 1;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int RW     = $clog2(SIDE);

  phase_e        phase;
  logic [1:0]    slot;
  logic [GW-1:0] grp;
  logic [RW-1:0] run;

  logic mirrored, is_run, boundary, run_cap, move_done;
  logic last_slot, last_grp;

  assign mirrored  = (phase == PH_LOWER) || (phase == PH_TAIL);
  assign last_slot = (slot == 2'd3);
  assign last_grp  = (grp == GW'(GROUPS - 1));
  assign run_cap   = (run == RW'(SIDE - 1));

  always_comb begin
    case (phase)
      PH_UPPER: move = upper_move(slot);
      PH_LOWER: move = lower_move(slot);
      PH_DIAG:  move = MV_SWEST;
      default:  move = MV_EAST;
    endcase
  end

  // Run termination: near edges in the upper part, far edges once mirrored
  always_comb begin
    is_run = move_repeats(move);
    if (mirrored)
      boundary = (move == MV_SWEST) ? at_south : at_east;
    else
      boundary = (move == MV_SWEST) ? at_west : at_north;
    move_done = !is_run || boundary || run_cap;
  end

  assign tail_step = step && (phase == PH_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_DONE;
      slot  <= '0;
      grp   <= '0;
      run   <= '0;
    end else if (launch) begin
      phase <= PH_LEAD;
      slot  <= '0;
      grp   <= '0;
      run   <= '0;
    end else if (step) begin
      if (!move_done) begin
        run <= run + RW'(1);
      end else begin
        run <= '0;
        case (phase)
          PH_LEAD: begin
            phase <= PH_UPPER;
            slot  <= '0;
            grp   <= '0;
          end
          PH_UPPER, PH_LOWER: begin
            if (!last_slot) begin
              slot <= slot + 2'd1;
            end else if (!last_grp) begin
              slot <= '0;
              grp  <= grp + GW'(1);
            end else begin
              slot  <= '0;
              grp   <= '0;
              phase <= (phase == PH_UPPER) ? PH_DIAG : PH_TAIL;
            end
          end
          PH_DIAG: begin
            phase <= PH_LOWER;
            slot  <= '0;
            grp   <= '0;
          end
          PH_TAIL: phase <= PH_DONE;
          default: phase <= PH_DONE;
        endcase
      end
    end
  end

  // A run always meets its edge before the step budget runs out
  assert_run_within_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && is_run |-> (run < RW'(SIDE - 1)));

  assert_no_step_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (phase != PH_DONE));

  assert_diag_ends_west_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && (phase == PH_DIAG) && move_done |-> at_west && at_south);

endmodule

// File: rtl/zz_addr_map.sv
module zz_addr_map
  import zz_scan_pkg::*;
#(
  parameter int SIDE = 8,
  parameter int CW   = 4,
  parameter int AW   = 6
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  output logic [AW-1:0] addr
);

  always_comb begin
    addr = AW'(lin_index(int'(x), int'(y), SIDE));
  end

endmodule

// File: rtl/zigzag_scan_gen.sv
module zigzag_scan_gen
  import zz_scan_pkg::*;
#(
  parameter int SIDE = 8,
  parameter int CW   = $clog2(SIDE + 1),
  parameter int AW   = $clog2(SIDE * SIDE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          advance,
  output logic          valid,
  output logic          last,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic [AW-1:0] addr
);

  localparam int NPTS = SIDE * SIDE;

  logic  valid_q, last_q;
  logic  launch, fire, step, tail_step;
  logic  at_west, at_north, at_east, at_south;
  move_e move;
  logic [AW:0] seen;

  // Named handshake events
  assign launch = start && !valid_q;
  assign fire   = valid_q && advance;
  assign step   = fire && !last_q;

  zz_seq_ctrl #(.SIDE(SIDE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .step      (step),
    .at_west   (at_west),
    .at_north  (at_north),
    .at_east   (at_east),
    .at_south  (at_south),
    .move      (move),
    .tail_step (tail_step)
  );

  zz_xy_counter #(.SIDE(SIDE), .CW(CW)) u_xy (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .step     (step),
    .move     (move),
    .x        (x),
    .y        (y),
    .at_west  (at_west),
    .at_north (at_north),
    .at_east  (at_east),
    .at_south (at_south)
  );

  zz_addr_map #(.SIDE(SIDE), .CW(CW), .AW(AW)) u_addr (
    .x    (x),
    .y    (y),
    .addr (addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      seen    <= '0;
    end else if (launch) begin
      valid_q <= 1'b1;
      last_q  <= 1'b0;
      seen    <= '0;
    end else if (fire) begin
      if (last_q) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end else begin
        last_q <= tail_step;
        seen   <= seen + (AW+1)'(1);
      end
    end
  end

  assign valid = valid_q;
  assign last  = last_q;

  assert_launch_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && start |=> valid && (x == CW'(1)) && (y == CW'(1)) && (addr == '0));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !advance |=> valid && $stable(x) && $stable(y) && $stable(last));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && start && !last && !((x == CW'(1)) && (y == CW'(1)))
      |=> valid && !((x == CW'(1)) && (y == CW'(1))));

  assert_last_at_corner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid && (x == CW'(SIDE)) && (y == CW'(SIDE)) && (seen == (AW+1)'(NPTS - 1)));

  assert_corner_only_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !last |-> !((x == CW'(SIDE)) && (y == CW'(SIDE))));

  assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && last && advance |=> !valid);

endmodule

// File: tb/zigzag_scan_gen_tb.sv
`timescale 1ns/1ps
module zigzag_scan_gen_tb;

  localparam int S    = 8;
  localparam int NPTS = S * S;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       advance = 1'b0;
  logic       valid, last;
  logic [3:0] x, y;
  logic [5:0] addr;

  int ref_x [NPTS];
  int ref_y [NPTS];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;   // 125 MHz

  zigzag_scan_gen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .advance (advance),
    .valid   (valid),
    .last    (last),
    .x       (x),
    .y       (y),
    .addr    (addr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference order: walk anti-diagonals, alternating direction
  task automatic build_ref();
    int k = 0;
    for (int d = 0; d <= 2*S-2; d++) begin
      for (int t = 0; t < S; t++) begin
        int c = (d % 2 == 1) ? (S - 1 - t) : t;
        int r = d - c;
        if (r >= 0 && r < S) begin
          ref_x[k] = c + 1;
          ref_y[k] = r + 1;
          k++;
        end
      end
    end
  endtask

  function automatic string seg_tag(input int k);
    if (k <= 28) return "R4";
    if (k <= 35) return "R5";
    return "R6";
  endfunction

  // Called at a negedge right after start was dropped
  task automatic scan(input bit stalls);
    int  k = 0;
    int  guard = 0;
    bit  held = 0;
    bit  poked = 0;
    int  px = 0, py = 0;
    while (k < NPTS && guard < 3000) begin
      bit adv;
      guard++;
      if (held)
        chk(valid && x == px && y == py, "R9 hold", int'(x)*16 + int'(y), px*16 + py);
      if (poked)
        chk(x == ref_x[k] && y == ref_y[k], "R10 busy start", int'(x)*16 + int'(y),
            ref_x[k]*16 + ref_y[k]);
      chk(valid, "R7 valid within scan", int'(valid), 1);
      chk(x == ref_x[k], {seg_tag(k), " x"}, int'(x), ref_x[k]);
      chk(y == ref_y[k], {seg_tag(k), " y"}, int'(y), ref_y[k]);
      chk(addr == (ref_y[k]-1)*S + (ref_x[k]-1), "R3 addr", int'(addr),
          (ref_y[k]-1)*S + (ref_x[k]-1));
      chk(last == (k == NPTS-1), "R7 last", int'(last), int'(k == NPTS-1));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      adv = stalls ? (lfsr[1:0] != 2'b00) : 1'b1;
      poked = stalls && (k == 20 || k == 21);
      start = poked;
      advance = adv;
      held = !adv;
      px = x;
      py = y;
      if (adv) k++;
      @(negedge clk);
    end
    start = 1'b0;
    advance = 1'b0;
    chk(k == NPTS, "R7 count", k, NPTS);
    chk(!valid, "R8 drop after last", int'(valid), 0);
  endtask

  task automatic launch_scan();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(valid && x == 1 && y == 1 && addr == 0, "R2 origin",
        int'(x)*16 + int'(y), 16 + 1);
  endtask

  initial begin
    build_ref();
    repeat (3) @(negedge clk);
    chk(!valid, "R1 valid", int'(valid), 0);
    chk(!last, "R1 last", int'(last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !last, "R1 after release", int'(valid), 0);

    launch_scan();
    scan(1'b0);

    advance = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!valid && !last, "R8 stays idle", int'(valid), 0);
    end
    advance = 1'b0;

    launch_scan();
    scan(1'b1);

    @(negedge clk);
    chk(!valid, "R8 idle at end", int'(valid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule